// File: doc/BRIEF.md
# Two-Pass Cycle Budget Sequencer

This block sequences a folded 2D inverse transform that runs two 1D passes on a single shared multiply-accumulate unit. Pass one forms an intermediate matrix from the transposed basis and the coefficient block. Pass two multiplies that intermediate by the basis. For each operation the block presents an output row, an output column and a dot-product term index, together with a pass flag and an accumulator write enable. The shared datapath uses these to fetch operands and to commit partial sums.

Errors in pass one spread across many outputs of pass two, so pass-one operations can be stretched to two clock cycles. The write enable is held low on the first cycle and raised on the second, which gives the adder a doubled settling window inside a fixed total frame time. A 1-bit phase register tracks the position within a stretched operation. A mode input, latched at start, selects one of two patterns. In the first, every pass-one operation is stretched. In the second, only the two lowest-frequency output elements are stretched. Pass two always uses one cycle per operation. A done pulse closes the frame.

Top module: `cb_seq_top`

## Requirements
- R1: During and after synchronous reset, with no start accepted, `acc_we_o` and `done_o` are 0 and `step_o`, `row_o`, `col_o` and `term_o` are 0.
- R2: A start pulse while idle makes the next cycle present pass one (`step_o`=0) at row 0, column 0, term 0.
- R3: With mode 0 (stretch all), every pass-one operation lasts two cycles. The indices are held, and `acc_we_o` is 0 on the first cycle and 1 on the second.
- R4: With mode 1 (low-frequency only), only pass-one operations with row 0 and column 0 or 1 last two cycles. Every other pass-one operation lasts one cycle with `acc_we_o`=1.
- R5: Every pass-two operation (`step_o`=1) lasts one cycle with `acc_we_o`=1.
- R6: Indices advance with the term index fastest, then the column, then the row, each running 0 to 7.
- R7: Pass two starts at row 0, column 0, term 0 in the cycle right after the last pass-one write.
- R8: `done_o` is high for exactly one cycle, in the cycle after the last pass-two write. In that cycle and afterwards, `acc_we_o` stays 0 until the next start.
- R9: A start while a frame is running has no effect, and the mode is sampled only when a start is accepted.
- R10: From the first presented cycle to the done cycle, a frame takes 1536 cycles in mode 0 and 1040 cycles in mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a frame when idle |
| mode_i | input | 1 | 0: stretch all pass-one ops; 1: stretch only the low-frequency ones |
| step_o | output | 1 | Current pass: 0 first, 1 second |
| row_o | output | 3 | Output row index |
| col_o | output | 3 | Output column index |
| term_o | output | 3 | Dot-product term index |
| acc_we_o | output | 1 | Accumulator write enable |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
A phase register stuck or out of step shows up within two cycles as a write enable in the wrong cycle of a stretched operation, or as a missing write in pass two. A faulty carry between the index counters breaks the term-then-column-then-row order at the first wrap, by cycle 16 of a frame. A wrong doubling decision or a wrong pass transition shifts every following index. The frame length then differs from 1536 or 1040 cycles, and the done pulse arrives at a different cycle. A mode or start that leaks in mid-frame changes the write pattern of the very next operation.

// File: rtl/cb_pkg.sv
package cb_pkg;
  typedef enum logic {MODE_ALL = 1'b0, MODE_LOWF = 1'b1} cb_mode_e;
  typedef enum logic {PASS_ONE = 1'b0, PASS_TWO = 1'b1} cb_pass_e;
  localparam int CB_LEVELS = 3;  // term, column, row
endpackage

// File: rtl/cb_wrapctr.sv
module cb_wrapctr #(
  parameter int LIMIT = 8,
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         last
);
  assign last = (q == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)  q <= '0;
    else if (inc)    q <= last ? '0 : q + 1'b1;
  end

  AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && !last) |=> (q == $past(q) + 1'b1)); // R6
  AST_CTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc && last) |=> (q == '0)); // R6
endmodule

// File: rtl/cb_phase.sv
module cb_phase (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic active,
  input  logic dbl,
  output logic phase,
  output logic op_end
);
  always_ff @(posedge clk) begin
    if (rst || clr)  phase <= 1'b0;
    else if (dbl)    phase <= ~phase;
    else             phase <= 1'b0;
  end

  assign op_end = active && (!dbl || phase);

  AST_PHASE_PAIR: assert property (@(posedge clk) disable iff (rst || clr)
    (dbl && !phase) |=> (phase && op_end)); // R3
  AST_PHASE_FIRST_QUIET: assert property (@(posedge clk) disable iff (rst)
    (dbl && !phase) |-> !op_end); // R3
endmodule

// File: rtl/cb_seq_top.sv
module cb_seq_top #(
  parameter int DIM       = 8,
  parameter int LOWF_COLS = 2,
  localparam int IW = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          mode_i,
  output logic          step_o,
  output logic [IW-1:0] row_o,
  output logic [IW-1:0] col_o,
  output logic [IW-1:0] term_o,
  output logic          acc_we_o,
  output logic          done_o
);
  import cb_pkg::*;

  logic          active_q, done_q;
  cb_pass_e      pass_q;
  cb_mode_e      mode_q;
  logic          launch, dbl, phase, op_end, pass_end;
  logic [IW-1:0] idx  [CB_LEVELS];
  logic [CB_LEVELS-1:0] last_v, inc_v;

  assign launch = start_i && !active_q;

  // Doubling decision: pass one only, all ops or the lowest-frequency outputs
  assign dbl = active_q && (pass_q == PASS_ONE) &&
               ((mode_q == MODE_ALL) ||
                ((idx[2] == '0) && (int'(idx[1]) < LOWF_COLS)));

  cb_phase u_phase (
    .clk(clk), .rst(rst), .clr(launch), .active(active_q),
    .dbl(dbl), .phase(phase), .op_end(op_end)
  );

  // Carry chain: term fastest, then column, then row
  always_comb begin
    inc_v[0] = op_end;
    for (int k = 1; k < CB_LEVELS; k++) inc_v[k] = inc_v[k-1] && last_v[k-1];
  end
  assign pass_end = inc_v[CB_LEVELS-1] && last_v[CB_LEVELS-1];

  for (genvar g = 0; g < CB_LEVELS; g++) begin : g_ctr
    cb_wrapctr #(.LIMIT(DIM)) u_ctr (
      .clk(clk), .rst(rst), .clr(launch), .inc(inc_v[g]),
      .q(idx[g]), .last(last_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pass_q   <= PASS_ONE;
      mode_q   <= MODE_ALL;
      done_q   <= 1'b0;
    end else begin
      done_q <= pass_end && (pass_q == PASS_TWO);
      if (launch) begin
        active_q <= 1'b1;
        pass_q   <= PASS_ONE;
        mode_q   <= cb_mode_e'(mode_i);
      end else if (pass_end) begin
        if (pass_q == PASS_ONE) pass_q <= PASS_TWO;
        else begin
          active_q <= 1'b0;
          pass_q   <= PASS_ONE;
        end
      end
    end
  end

  assign step_o   = pass_q;
  assign term_o   = idx[0];
  assign col_o    = idx[1];
  assign row_o    = idx[2];
  assign acc_we_o = op_end;
  assign done_o   = done_q;

  AST_LAUNCH_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    launch |=> (active_q && step_o == 1'b0 && row_o == '0 && col_o == '0 && term_o == '0)); // R2
  AST_PASS2_WRITES: assert property (@(posedge clk) disable iff (rst)
    (active_q && pass_q == PASS_TWO) |-> acc_we_o); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!active_q && !acc_we_o)); // R8
  AST_BUSY_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (start_i && active_q) |=> $stable(mode_q)); // R9
endmodule

// File: tb/sim_cb_seq_top.sv
`timescale 1ns/1ps
module sim_cb_seq_top;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0, mode = 1'b0;
  logic       step, we, done;
  logic [2:0] row, col, term;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  cb_seq_top u0 (
    .clk(clk), .rst(rst), .start_i(start), .mode_i(mode),
    .step_o(step), .row_o(row), .col_o(col), .term_o(term),
    .acc_we_o(we), .done_o(done)
  );

  task automatic chk(bit ok, string rq, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic expect_cycle(int st, int r, int c, int t, bit ewe, string rwe, string ridx);
    chk(step == st, ridx, step, st);
    chk({row, col, term} == 9'(r*64 + c*8 + t), ridx, {row, col, term}, r*64 + c*8 + t);
    chk(we == ewe, rwe, we, ewe);
    chk(done == 1'b0, "R8", done, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b1;
    repeat (3) @(negedge clk);
    chk(we == 0 && done == 0, "R1", {we, done}, 0);
    chk({step, row, col, term} == 10'd0, "R1", {step, row, col, term}, 0);
    start = 1'b0; rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(we == 0 && done == 0, "R1", {we, done}, 0);
    chk({step, row, col, term} == 10'd0, "R1", {step, row, col, term}, 0);
  endtask

  // One full frame; disturb raises start and flips mode mid-frame (R9)
  task automatic t_frame(bit m, bit disturb);
    int cyc = 0;
    @(negedge clk); start = 1'b1; mode = m;
    @(negedge clk); start = 1'b0;
    for (int st = 0; st < 2; st++)
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++)
          for (int t = 0; t < 8; t++) begin
            bit d = (st == 0) && (m == 1'b0 || (r == 0 && c < 2));
            string rw = (st == 1) ? "R5" : (m ? "R4" : "R3");
            string ri = (st == 1 && r == 0 && c == 0 && t == 0) ? "R7" :
                        (cyc == 0 ? "R2" : "R6");
            if (disturb) rw = (st == 1) ? "R5" : "R9";
            for (int p = (d ? 0 : 1); p < 2; p++) begin
              expect_cycle(st, r, c, t, p == 1, rw, ri);
              if (disturb && cyc == 100) begin start = 1'b1; mode = ~m; end
              else if (disturb && cyc == 101) start = 1'b0;
              @(negedge clk);
              cyc++;
            end
          end
    chk(done == 1'b1, "R8", done, 1);
    chk(we == 1'b0, "R8", we, 0);
    chk(cyc == (m ? 1040 : 1536), "R10", cyc, m ? 1040 : 1536);
    @(negedge clk);
    chk(done == 1'b0, "R8", done, 0);
    chk(we == 1'b0, "R8", we, 0);
    mode = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_frame(1'b0, 1'b0);   // R3 all stretched
    t_frame(1'b1, 1'b0);   // R4 low-frequency only
    t_frame(1'b1, 1'b1);   // R9 start/mode ignored while running
    t_frame(1'b0, 1'b1);   // R9 other mode
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule